// File: doc/BRIEF.md
# Base-Limit Memory Protection Unit

This block checks every memory access against a small table of protection regions. Each region is a contiguous address window given by an aligned start address and an inclusive end address. The same table serves instruction fetches and data accesses. A region carries an execute-never flag, a two-bit permission code, a shareability code, an enable bit and a three-bit index into a table of eight 8-bit memory attributes.

Software fills the table through a 32-bit register port: one register selects a region, two registers reach the selected region's base and limit words, three more base/limit pairs reach the next regions of the same aligned group of four, and two registers hold the attribute table. The lookup side is purely combinational. An address with privilege, write and fetch flags goes in. Out come a hit flag, the region number, a fault flag and the resolved attribute byte. Regions have no priority, so an address covered by two enabled regions is a configuration error and is reported as a fault.

Top module: `bl_mpu`

## Requirements
- R1: An enabled region matches an address when address bits [31:G] lie between base bits [31:G] and limit bits [31:G], both ends included. G is GRAN_LOG2 (5 or 6). The limit's low G bits therefore act as all ones.
- R2: In the limit word, bit 0 enables the region and bits [3:1] are the attribute index. In the base word, bit 0 is execute-never, bits [2:1] are the permission code and bits [4:3] are shareability. A disabled region never matches.
- R3: Permission code 00 allows read and write to privileged accesses only. Code 01 allows read and write at both levels. Code 10 allows privileged reads only. Code 11 allows reads at both levels. Any access outside what the code allows raises lk_fault.
- R4: An instruction fetch counts as a read for permissions and uses the same region entries as data accesses. A fetch from a region with execute-never set raises lk_fault.
- R5: When two or more enabled regions match, lk_hit is 0, lk_fault is 1, and lk_region and lk_attr are 0.
- R6: When no enabled region matches, lk_hit is 0, lk_fault is 1, and lk_region and lk_attr are 0.
- R7: On a single match, lk_attr is byte n of the 64-bit value {attribute word 1, attribute word 0}, where n is the region's attribute index. Indices 0-3 come from word 0 and 4-7 from word 1, lowest byte first.
- R8: The register offsets are: select 0x98, base 0x9C, limit 0xA0, attribute word 0 at 0xC0, attribute word 1 at 0xC4. reg_rdata shows the addressed register in the same cycle while reg_re is high. Unmapped offsets read zero. Writes take effect at the clock edge where reg_we is high.
- R9: The base/limit pair at 0x9C+8n / 0xA0+8n, for n = 1 to 3, reaches region (select with its low two bits cleared) + n. For n = 0 it reaches the selected region.
- R10: A region access whose target number is at or beyond NUM_RGN leaves every region unchanged on a write and reads zero.
- R11: Reset clears the select register, every region word (including the enables) and both attribute words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| lk_addr | input | 32 | Access address to check |
| lk_priv | input | 1 | Access is privileged |
| lk_write | input | 1 | Access is a write |
| lk_fetch | input | 1 | Access is an instruction fetch |
| lk_hit | output | 1 | Exactly one enabled region matched |
| lk_region | output | 4 | Number of the matching region |
| lk_fault | output | 1 | Access is refused |
| lk_attr | output | 8 | Resolved memory attribute byte |

## Verification
The lookup path has no state, so a wrong stored region word or attribute word shows up at the lookup outputs in the cycle after the write that stored it, as soon as an address inside the affected window is presented. A corrupted enable bit or alias decode makes a window vanish (a miss fault) or appear twice (an overlap fault). A wrong attribute byte shows on lk_attr for every address of a region that points to it. Read-back through the register port exposes a wrong stored word in the same cycle as the read strobe, which isolates storage faults from decode faults in the match logic.

// File: rtl/blmpu_pkg.sv
package blmpu_pkg;
  localparam logic [7:0] OFS_SEL   = 8'h98;
  localparam logic [7:0] OFS_BASE  = 8'h9C;
  localparam logic [7:0] OFS_LAST  = 8'hB8;
  localparam logic [7:0] OFS_ATTR0 = 8'hC0;
  localparam logic [7:0] OFS_ATTR1 = 8'hC4;

  typedef enum logic [1:0] {
    AP_PRIV_RW = 2'b00,
    AP_ALL_RW  = 2'b01,
    AP_PRIV_RO = 2'b10,
    AP_ALL_RO  = 2'b11
  } ap_e;
endpackage

// File: rtl/blmpu_regfile.sv
module blmpu_regfile
  import blmpu_pkg::*;
#(
  parameter int NUM_RGN = 16,
  localparam int RW = $clog2(NUM_RGN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic                     reg_re,
  input  logic [7:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic [NUM_RGN-1:0][31:0] base_o,
  output logic [NUM_RGN-1:0][31:0] lim_o,
  output logic [63:0]              attr_o
);
  localparam logic [7:0] NUM_RGN_B = 8'(NUM_RGN);

  logic [7:0]               sel_q, sel_d;
  logic [NUM_RGN-1:0][31:0] base_q, base_d;
  logic [NUM_RGN-1:0][31:0] lim_q, lim_d;
  logic [63:0]              attr_q, attr_d;

  logic [7:0]    off;
  logic          in_win;
  logic [1:0]    grp_n;
  logic          is_lim;
  logic [7:0]    tgt;
  logic          tgt_ok;
  logic [RW-1:0] tgt_idx;

  // decode of the region window and its aliases
  always_comb begin
    off     = reg_addr - OFS_BASE;
    in_win  = (reg_addr >= OFS_BASE) && (reg_addr <= OFS_LAST) && (reg_addr[1:0] == 2'b00);
    grp_n   = off[4:3];
    is_lim  = off[2];
    tgt     = (grp_n == 2'd0) ? sel_q : {sel_q[7:2], grp_n};
    tgt_ok  = tgt < NUM_RGN_B;
    tgt_idx = tgt[RW-1:0];
  end

  // next state
  always_comb begin
    sel_d  = sel_q;
    base_d = base_q;
    lim_d  = lim_q;
    attr_d = attr_q;
    if (reg_addr == OFS_SEL)   sel_d = reg_wdata[7:0];
    if (reg_addr == OFS_ATTR0) attr_d[31:0]  = reg_wdata;
    if (reg_addr == OFS_ATTR1) attr_d[63:32] = reg_wdata;
    if (in_win && tgt_ok) begin
      if (is_lim) lim_d[tgt_idx]  = reg_wdata;
      else        base_d[tgt_idx] = reg_wdata;
    end
  end

  // registers, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      base_q <= '0;
      lim_q  <= '0;
      attr_q <= '0;
    end else if (reg_we) begin
      sel_q  <= sel_d;
      base_q <= base_d;
      lim_q  <= lim_d;
      attr_q <= attr_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_re) begin
      if (reg_addr == OFS_SEL)        reg_rdata = {24'd0, sel_q};
      else if (reg_addr == OFS_ATTR0) reg_rdata = attr_q[31:0];
      else if (reg_addr == OFS_ATTR1) reg_rdata = attr_q[63:32];
      else if (in_win && tgt_ok)      reg_rdata = is_lim ? lim_q[tgt_idx] : base_q[tgt_idx];
    end
  end

  assign base_o = base_q;
  assign lim_o  = lim_q;
  assign attr_o = attr_q;

  assert_attr0_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_ATTR0) |=> (attr_q[31:0] == $past(reg_wdata)));

  assert_oor_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && in_win && !tgt_ok) |=> ($stable(base_q) && $stable(lim_q)));
endmodule

// File: rtl/blmpu_rgn_cmp.sv
module blmpu_rgn_cmp #(
  parameter int GRAN_LOG2 = 5
) (
  input  logic [31:0] addr,
  input  logic [31:0] base,
  input  logic [31:0] lim,
  output logic        match
);
  logic [31-GRAN_LOG2:0] a_g, b_g, l_g;

  always_comb begin
    a_g   = addr[31:GRAN_LOG2];
    b_g   = base[31:GRAN_LOG2];
    l_g   = lim[31:GRAN_LOG2];
    match = lim[0] && (a_g >= b_g) && (a_g <= l_g);
  end
endmodule

// File: rtl/blmpu_resolve.sv
module blmpu_resolve
  import blmpu_pkg::*;
#(
  parameter int NUM_RGN = 16,
  localparam int RW = $clog2(NUM_RGN),
  localparam int CW = $clog2(NUM_RGN + 1)
) (
  input  logic [NUM_RGN-1:0]       match,
  input  logic [NUM_RGN-1:0][31:0] base_i,
  input  logic [NUM_RGN-1:0][31:0] lim_i,
  input  logic [63:0]              attr_i,
  input  logic                     priv,
  input  logic                     write,
  input  logic                     fetch,
  output logic                     hit,
  output logic [RW-1:0]            region,
  output logic                     fault,
  output logic [7:0]               attr
);
  logic [CW-1:0] cnt;
  logic [RW-1:0] idx;
  logic [31:0]   b_sel, l_sel;
  logic          perm_bad, xn_bad;
  ap_e           ap;

  always_comb begin
    cnt = '0;
    idx = '0;
    for (int i = 0; i < NUM_RGN; i++) begin
      if (match[i]) begin
        cnt = cnt + CW'(1);
        idx = RW'(i);
      end
    end
    b_sel = base_i[idx];
    l_sel = lim_i[idx];
    ap    = ap_e'(b_sel[2:1]);
    unique case (ap)
      AP_PRIV_RW: perm_bad = !priv;
      AP_ALL_RW:  perm_bad = 1'b0;
      AP_PRIV_RO: perm_bad = !priv || write;
      AP_ALL_RO:  perm_bad = write;
      default:    perm_bad = 1'b1;
    endcase
    xn_bad = fetch && b_sel[0];
    hit    = (cnt == CW'(1));
    region = hit ? idx : '0;
    fault  = !hit || perm_bad || xn_bad;
    attr   = hit ? attr_i[{l_sel[3:1], 3'b000} +: 8] : 8'd0;
  end
endmodule

// File: rtl/bl_mpu.sv
module bl_mpu
  import blmpu_pkg::*;
#(
  parameter int NUM_RGN   = 16,
  parameter int GRAN_LOG2 = 5,
  localparam int RW = $clog2(NUM_RGN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [31:0]   lk_addr,
  input  logic          lk_priv,
  input  logic          lk_write,
  input  logic          lk_fetch,
  output logic          lk_hit,
  output logic [RW-1:0] lk_region,
  output logic          lk_fault,
  output logic [7:0]    lk_attr
);
  logic [NUM_RGN-1:0][31:0] base_w, lim_w;
  logic [63:0]              attr_w;
  logic [NUM_RGN-1:0]       match_w;

  blmpu_regfile #(.NUM_RGN(NUM_RGN)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .base_o(base_w), .lim_o(lim_w), .attr_o(attr_w)
  );

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
    blmpu_rgn_cmp #(.GRAN_LOG2(GRAN_LOG2)) u_cmp (
      .addr(lk_addr), .base(base_w[g]), .lim(lim_w[g]), .match(match_w[g])
    );
  end

  blmpu_resolve #(.NUM_RGN(NUM_RGN)) u_res (
    .match(match_w), .base_i(base_w), .lim_i(lim_w), .attr_i(attr_w),
    .priv(lk_priv), .write(lk_write), .fetch(lk_fetch),
    .hit(lk_hit), .region(lk_region), .fault(lk_fault), .attr(lk_attr)
  );

  assert_hit_matches_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> match_w[lk_region]);

  assert_xn_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_fetch && base_w[lk_region][0]) |-> lk_fault);

  assert_nohit_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_attr == 8'd0 && lk_region == '0));

  assert_nohit_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_fault);
endmodule

// File: tb/bl_mpu_test.sv
`timescale 1ns/100ps
module bl_mpu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, reg_re;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [31:0] lk_addr;
  logic        lk_priv, lk_write, lk_fetch;
  logic        lk_hit, lk_fault;
  logic [3:0]  lk_region;
  logic [7:0]  lk_attr;

  always #2.5 clk = ~clk;

  bl_mpu uut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_addr(lk_addr), .lk_priv(lk_priv), .lk_write(lk_write), .lk_fetch(lk_fetch),
    .lk_hit(lk_hit), .lk_region(lk_region), .lk_fault(lk_fault), .lk_attr(lk_attr)
  );

  typedef struct {
    bit          is_rd;
    logic [31:0] rdata;
    logic        hit;
    logic [3:0]  rgn;
    logic        fault;
    logic [7:0]  attr;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;

  // monitor: compare one expected item one ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_run++;
      if (e.is_rd) begin
        if (reg_rdata !== e.rdata) begin
          n_fail++;
          $display("FAIL %s rdata actual=%h expected=%h", e.tag, reg_rdata, e.rdata);
        end
      end else if (lk_hit !== e.hit || lk_region !== e.rgn || lk_fault !== e.fault || lk_attr !== e.attr) begin
        n_fail++;
        $display("FAIL %s actual hit=%b rgn=%0d fault=%b attr=%h expected hit=%b rgn=%0d fault=%b attr=%h",
                 e.tag, lk_hit, lk_region, lk_fault, lk_attr, e.hit, e.rgn, e.fault, e.attr);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_re = 1'b0; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] x, input string tag);
    exp_t it;
    @(negedge clk);
    reg_we = 1'b0; reg_re = 1'b1; reg_addr = a;
    it.is_rd = 1'b1; it.rdata = x; it.hit = 1'b0; it.rgn = '0; it.fault = 1'b0; it.attr = '0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic lk(input logic [31:0] a, input logic p, input logic w, input logic f,
                    input logic h, input logic [3:0] r, input logic flt, input logic [7:0] at,
                    input string tag);
    exp_t it;
    @(negedge clk);
    reg_we = 1'b0; reg_re = 1'b0;
    lk_addr = a; lk_priv = p; lk_write = w; lk_fetch = f;
    it.is_rd = 1'b0; it.rdata = '0; it.hit = h; it.rgn = r; it.fault = flt; it.attr = at; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_re = 1'b0; reg_addr = '0; reg_wdata = '0;
    lk_addr = '0; lk_priv = 1'b0; lk_write = 1'b0; lk_fetch = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    rd(8'hC0, 32'h0, "R11 attr0 after reset");
    rd(8'hA0, 32'h0, "R11 limit0 after reset");
    lk(32'h1000, 1, 0, 0, 0, 0, 1, 8'h00, "R11 no region enabled after reset");

    // program attributes and four regions through the aliases
    wr(8'hC0, 32'h0A0B0C0D);
    wr(8'hC4, 32'h1A1B1C1D);
    wr(8'h98, 32'h0);
    wr(8'h9C, 32'h0000_1000);  // AP 00
    wr(8'hA0, 32'h0000_1FE3);  // idx1, en
    wr(8'hA4, 32'h0000_2003);  // AP 01, XN
    wr(8'hA8, 32'h0000_2FEB);  // idx5, en
    wr(8'hAC, 32'h0000_3006);  // AP 11
    wr(8'hB0, 32'h0000_3FEF);  // idx7, en
    wr(8'hB4, 32'h0000_3802);  // AP 01
    wr(8'hB8, 32'h0000_4FE0);  // disabled

    rd(8'h98, 32'h0, "R8 select read");
    rd(8'hA4, 32'h0000_2003, "R9 alias base read");
    rd(8'hC4, 32'h1A1B1C1D, "R8 attr1 read");
    rd(8'h50, 32'h0, "R8 unmapped read");

    lk(32'h1000, 1, 0, 0, 1, 0, 0, 8'h0C, "R1 base boundary");
    lk(32'h1FFF, 1, 1, 0, 1, 0, 0, 8'h0C, "R1 limit low bits as ones");
    lk(32'h0FFF, 1, 0, 0, 0, 0, 1, 8'h00, "R6 miss below region");
    lk(32'h1010, 0, 0, 0, 1, 0, 1, 8'h0C, "R3 unpriv to priv-only");
    lk(32'h2040, 0, 1, 0, 1, 1, 0, 8'h1C, "R3 R7 all-rw write");
    lk(32'h2040, 1, 0, 1, 1, 1, 1, 8'h1C, "R4 fetch from XN");
    lk(32'h3004, 0, 0, 0, 1, 2, 0, 8'h1A, "R3 read-only read");
    lk(32'h3004, 1, 1, 0, 1, 2, 1, 8'h1A, "R3 read-only write");
    lk(32'h3004, 1, 0, 1, 1, 2, 0, 8'h1A, "R4 fetch same unified region");
    lk(32'h3900, 1, 0, 0, 1, 2, 0, 8'h1A, "R2 disabled region ignored");

    wr(8'hB8, 32'h0000_4FE1);
    lk(32'h3900, 1, 0, 0, 0, 0, 1, 8'h00, "R5 overlap");
    lk(32'h4100, 0, 1, 0, 1, 3, 0, 8'h0D, "R7 index0");

    wr(8'hAC, 32'h0000_3004);  // AP 10
    lk(32'h3010, 1, 0, 0, 1, 2, 0, 8'h1A, "R3 priv-ro read");
    lk(32'h3010, 1, 1, 0, 1, 2, 1, 8'h1A, "R3 priv-ro write");
    lk(32'h3010, 0, 0, 0, 1, 2, 1, 8'h1A, "R3 priv-ro unpriv read");

    wr(8'h98, 32'h5);
    wr(8'h9C, 32'h0000_6002);
    wr(8'hA0, 32'h0000_6FE1);
    wr(8'hB4, 32'h0000_7002);
    wr(8'hB8, 32'h0000_7FE3);
    rd(8'h9C, 32'h0000_6002, "R8 selected base read");
    lk(32'h6000, 0, 0, 0, 1, 5, 0, 8'h0D, "R9 selected region 5");
    lk(32'h7FF0, 0, 1, 0, 1, 7, 0, 8'h0C, "R9 alias to region 7");

    wr(8'h98, 32'h11);
    wr(8'h9C, 32'h0000_8000);
    wr(8'hA0, 32'h0000_8FE1);
    wr(8'hB8, 32'h0000_8FE1);
    rd(8'h9C, 32'h0, "R10 out-of-range base read");
    rd(8'hA0, 32'h0, "R10 out-of-range limit read");
    lk(32'h8000, 1, 0, 0, 0, 0, 1, 8'h00, "R10 out-of-range write ignored");
    lk(32'h6004, 0, 0, 0, 1, 5, 0, 8'h0D, "R10 region 5 untouched");

    @(negedge clk);
    reg_re = 1'b0;
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule